// File: doc/BRIEF.md
# Clock-Buffer Control Register Serial Slave

This block is the two-wire serial control port of a clock buffer. It keeps seven 8-bit control registers whose bits switch individual differential clock pairs on and off, and it lets a host load and inspect them over a standard-mode I2C bus. SCL and SDA are sampled with the fast system clock through two-flop synchronizers, so bus edges, START and STOP are all recovered in the system clock domain. SDA is driven through an open-drain enable: a high `sda_oe` pulls the line low.

The transaction set is deliberately narrow. A write addresses the device, sends a command byte and a count byte that are acknowledged and thrown away, and then streams data that always fills register 0 first, then 1, and so on. A read addresses the device and receives a count byte followed by every register in ascending order. There is no random access. The top three bits of the last register are locked so that host writes cannot disturb them.

Top module: `i2cb_ctrl_slave`

## Requirements
- R1: After reset, registers 0 to 5 hold 0xFF, register 6 holds 0x1F, and `sda_oe` is low.
- R2: The slave acknowledges only the address bytes 0xD4 (write) and 0xD5 (read), i.e. 7-bit address 0x6A with the R/W bit in bit 0; any other address gets no acknowledge, the slave keeps SDA released until the next START or STOP, and no register changes.
- R3: In a write, the slave acknowledges the command byte and the count byte without storing them, then stores data bytes into register 0, 1, 2, ... in that order, acknowledging each; `ctrl_regs` bits [8k+7:8k] hold register k.
- R4: A STOP after any complete data byte keeps the registers already written and leaves all later registers unchanged.
- R5: Data bytes after register 6 has been written are acknowledged and discarded.
- R6: Bits 7:5 of register 6 keep their reset value 0 regardless of the data written; bits 4:0 take the written value.
- R7: In a read, after acknowledging 0xD5 the slave sends the byte 0x07, then registers 0 to 6, each MSB first, advancing on every host acknowledge.
- R8: A host NACK ends a read: the slave leaves SDA released for every following clock until START or STOP, and a repeated START begins a new transaction.
- R9: A START in the middle of a byte abandons the transaction without storing the partial byte; the bytes that follow are decoded from the address byte.
- R10: `pair_en` bit p enables clock pair p: pairs 0, 2, 3, 4, 9 and 1 come from register 5 bits 7, 6, 5, 4, 3 and 2; pairs 8, 7, 6 and 5 come from register 6 bits 4, 3, 2 and 1; 1 means enabled.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| ctrl_regs | output | 56 | All registers, register k in bits [8k+7:8k] |
| pair_en | output | 10 | Per clock-pair enable, 1 = enabled |

## Verification
The assertions assume that SCL and SDA never change in the same system clock, that the host changes SDA only while SCL has been low for several system clocks, and that the host never issues START or STOP while the slave is pulling SDA low. The bench host drives SDA a quarter bit after each SCL fall and places every START and STOP a quarter bit away from SCL edges, with SDA released by both sides. Random write lengths from zero to nine bytes and random data stay inside this framing; only the directed mid-byte START changes the byte structure.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_RX_ACK,
      PH_TX,
      PH_TX_ACK,
      PH_WAIT
   } phase_t;

   // Reset value of register idx in a file of nreg registers.
   function automatic logic [BYTE_W-1:0] reg_default(input int idx, input int nreg);
      return (idx == nreg - 1) ? 8'h1F : 8'hFF;
   endfunction

   // Bits of register idx that host writes must never alter.
   function automatic logic [BYTE_W-1:0] reg_lock(input int idx, input int nreg);
      return (idx == nreg - 1) ? 8'hE0 : 8'h00;
   endfunction

endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
   parameter int LINES  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] din,
   output logic [LINES-1:0] lvl,
   output logic [LINES-1:0] rise,
   output logic [LINES-1:0] fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2cb_sync needs at least two stages");
   end

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [STAGES:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= '1;
         else        pipe <= {pipe[STAGES-1:0], din[l]};
      end
      assign lvl[l]  = pipe[STAGES-1];
      assign rise[l] = pipe[STAGES-1] & ~pipe[STAGES];
      assign fall[l] = ~pipe[STAGES-1] & pipe[STAGES];
   end

endmodule

// File: rtl/i2cb_regfile.sv
module i2cb_regfile
   import i2cb_pkg::*;
#(
   parameter int NREG  = 7,
   parameter int IDX_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [IDX_W-1:0]       widx,
   input  logic [BYTE_W-1:0]      wdata,
   output logic [NREG*BYTE_W-1:0] q
);

   if ((1 << IDX_W) <= NREG) begin : g_bad_idx
      $error("i2cb_regfile index too narrow");
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      localparam logic [BYTE_W-1:0] LOCK = reg_lock(r, NREG);
      logic [BYTE_W-1:0] val;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            val <= reg_default(r, NREG);
         else if (we && widx == IDX_W'(r))
            val <= (wdata & ~LOCK) | (val & LOCK);
      end
      assign q[r*BYTE_W +: BYTE_W] = val;

      if (LOCK != '0) begin : g_lock_chk
         AST_LOCKED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(val & LOCK)); // R6
      end
   end

endmodule

// File: rtl/i2cb_ctrl_slave.sv
module i2cb_ctrl_slave
   import i2cb_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h6A,
   parameter int         NREG        = 7,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   output logic                   sda_oe,
   output logic [NREG*BYTE_W-1:0] ctrl_regs,
   output logic [9:0]             pair_en
);

   localparam int IDX_W = $clog2(NREG + 2);

   if (NREG < 7) begin : g_bad_nreg
      $error("i2cb_ctrl_slave needs at least seven registers");
   end

   logic [1:0] lvl, rise, fall;
   i2cb_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({sda_i, scl_i}),
      .lvl  (lvl),
      .rise (rise),
      .fall (fall)
   );

   logic scl_s, sda_s, scl_r, scl_f, start_det, stop_det;
   assign scl_s     = lvl[0];
   assign sda_s     = lvl[1];
   assign scl_r     = rise[0];
   assign scl_f     = fall[0];
   assign start_det = scl_s & fall[1];
   assign stop_det  = scl_s & rise[1];

   phase_t            ph;
   logic [2:0]        bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic              rd_mode;
   logic [1:0]        hdr;      // 0 address, 1 command, 2 count, 3 data
   logic [IDX_W-1:0]  ptr;
   logic              oe;
   logic              byte_done;
   logic              host_ack;

   logic              reg_we;
   logic [BYTE_W-1:0] tx_byte;

   assign reg_we = (ph == PH_RX) && scl_f && byte_done && !start_det && !stop_det
                   && (hdr == 2'd3) && (ptr < IDX_W'(NREG));

   i2cb_regfile #(.NREG(NREG), .IDX_W(IDX_W)) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (reg_we),
      .widx (ptr),
      .wdata(shreg),
      .q    (ctrl_regs)
   );

   // Read stream: slot 0 is the register count, slot k+1 is register k.
   always_comb begin
      tx_byte = (ptr == '0) ? BYTE_W'(NREG) : '0;
      for (int k = 0; k < NREG; k++)
         if (ptr == IDX_W'(k + 1)) tx_byte = ctrl_regs[k*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         bit_cnt   <= '0;
         shreg     <= '0;
         rd_mode   <= 1'b0;
         hdr       <= '0;
         ptr       <= '0;
         oe        <= 1'b0;
         byte_done <= 1'b0;
         host_ack  <= 1'b0;
      end else if (start_det) begin
         ph        <= PH_RX;
         bit_cnt   <= '0;
         byte_done <= 1'b0;
         hdr       <= '0;
         ptr       <= '0;
         rd_mode   <= 1'b0;
         oe        <= 1'b0;
      end else if (stop_det) begin
         ph <= PH_IDLE;
         oe <= 1'b0;
      end else begin
         unique case (ph)
            PH_RX: begin
               if (scl_r) begin
                  shreg   <= {shreg[BYTE_W-2:0], sda_s};
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == 3'd7) byte_done <= 1'b1;
               end else if (scl_f && byte_done) begin
                  byte_done <= 1'b0;
                  if (hdr == 2'd0) begin
                     if (shreg[7:1] == DEV_ADDR) begin
                        oe      <= 1'b1;
                        rd_mode <= shreg[0];
                        ph      <= PH_RX_ACK;
                     end else begin
                        ph <= PH_WAIT;
                     end
                  end else begin
                     oe <= 1'b1;
                     ph <= PH_RX_ACK;
                     if (hdr == 2'd3 && ptr != IDX_W'(NREG)) ptr <= ptr + 1'b1;
                  end
                  if (hdr != 2'd3) hdr <= hdr + 2'd1;
               end
            end
            PH_RX_ACK: begin
               if (scl_f) begin
                  if (rd_mode) begin
                     shreg <= tx_byte;
                     oe    <= ~tx_byte[BYTE_W-1];
                     ptr   <= ptr + 1'b1;
                     ph    <= PH_TX;
                  end else begin
                     oe <= 1'b0;
                     ph <= PH_RX;
                  end
               end
            end
            PH_TX: begin
               if (scl_r) begin
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == 3'd7) byte_done <= 1'b1;
               end else if (scl_f) begin
                  if (byte_done) begin
                     byte_done <= 1'b0;
                     oe        <= 1'b0;
                     ph        <= PH_TX_ACK;
                  end else begin
                     shreg <= {shreg[BYTE_W-2:0], 1'b0};
                     oe    <= ~shreg[BYTE_W-2];
                  end
               end
            end
            PH_TX_ACK: begin
               if (scl_r) begin
                  host_ack <= ~sda_s;
               end else if (scl_f) begin
                  if (host_ack && ptr <= IDX_W'(NREG)) begin
                     shreg <= tx_byte;
                     oe    <= ~tx_byte[BYTE_W-1];
                     ptr   <= ptr + 1'b1;
                     ph    <= PH_TX;
                  end else begin
                     ph <= PH_WAIT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe = oe;

   // R10: pair enables picked out of registers 5 and 6
   assign pair_en[0] = ctrl_regs[5*BYTE_W + 7];
   assign pair_en[1] = ctrl_regs[5*BYTE_W + 2];
   assign pair_en[2] = ctrl_regs[5*BYTE_W + 6];
   assign pair_en[3] = ctrl_regs[5*BYTE_W + 5];
   assign pair_en[4] = ctrl_regs[5*BYTE_W + 4];
   assign pair_en[9] = ctrl_regs[5*BYTE_W + 3];
   assign pair_en[8] = ctrl_regs[6*BYTE_W + 4];
   assign pair_en[7] = ctrl_regs[6*BYTE_W + 3];
   assign pair_en[6] = ctrl_regs[6*BYTE_W + 2];
   assign pair_en[5] = ctrl_regs[6*BYTE_W + 1];

   AST_RELEASED_WHEN_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_WAIT || ph == PH_IDLE) |-> !oe); // R8

   AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s) && !start_det && !stop_det) |-> $stable(oe)); // R11

   AST_WRITE_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (!rd_mode && ph == PH_RX)); // R3

   AST_START_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (ph == PH_RX && bit_cnt == 3'd0 && hdr == 2'd0 && !oe)); // R9

   AST_READ_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_mode) |-> oe); // R7

endmodule

// File: tb/tb_i2cb_ctrl_slave.sv
module tb_i2cb_ctrl_slave;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n;
   logic        host_scl = 1'b1;
   logic        host_low = 1'b0;
   logic        sda_oe;
   logic        sda_bus;
   logic [55:0] ctrl_regs;
   logic [9:0]  pair_en;

   assign sda_bus = !(host_low || sda_oe);

   i2cb_ctrl_slave dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (host_scl),
      .sda_i    (sda_bus),
      .sda_oe   (sda_oe),
      .ctrl_regs(ctrl_regs),
      .pair_en  (pair_en)
   );

   int n_chk = 0;
   int n_bad = 0;
   int oe_viol = 0;
   logic done = 1'b0;
   logic prev_oe = 1'b0;
   logic [7:0] mdl [7];
   logic [7:0] wbuf [10];

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R11 monitor: the slave may not move SDA while SCL is high
   always @(negedge clk) begin
      if (rst_n === 1'b1 && host_scl && sda_oe !== prev_oe) oe_viol++;
      prev_oe = sda_oe;
   end

   function automatic logic [55:0] mdl_bus();
      logic [55:0] b;
      for (int i = 0; i < 7; i++) b[i*8 +: 8] = mdl[i];
      return b;
   endfunction

   function automatic logic [9:0] exp_pairs();
      logic [9:0] p;
      p[0] = mdl[5][7]; p[1] = mdl[5][2]; p[2] = mdl[5][6]; p[3] = mdl[5][5];
      p[4] = mdl[5][4]; p[9] = mdl[5][3]; p[8] = mdl[6][4]; p[7] = mdl[6][3];
      p[6] = mdl[6][2]; p[5] = mdl[6][1];
      return p;
   endfunction

   task automatic q();
      repeat (8) @(negedge clk);
   endtask

   task automatic bus_start();
      host_low = 1'b0; q(); host_scl = 1'b1; q(); host_low = 1'b1; q(); host_scl = 1'b0; q();
   endtask

   task automatic bus_stop();
      host_low = 1'b1; q(); host_scl = 1'b1; q(); host_low = 1'b0; q(); q();
   endtask

   task automatic wbit(input logic b);
      host_low = !b; q(); host_scl = 1'b1; q(); q(); host_scl = 1'b0; q();
   endtask

   task automatic rbit(output logic b);
      host_low = 1'b0; q(); host_scl = 1'b1; q(); b = sda_bus; q(); host_scl = 1'b0; q();
   endtask

   task automatic wbyte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) wbit(d[i]);
      rbit(b);
      ack = !b;
   endtask

   task automatic rbyte(output logic [7:0] d, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         rbit(b);
         d[i] = b;
      end
      wbit(!give_ack);
   endtask

   // Write n data bytes from wbuf, then STOP; updates the model.
   task automatic do_write(input int n);
      logic a;
      bus_start();
      wbyte(8'hD4, a);                        chk("R2 write address ack", a, 1);
      wbyte(8'($urandom), a);                 chk("R3 command ack", a, 1);
      wbyte(8'($urandom), a);                 chk("R3 count ack", a, 1);
      for (int i = 0; i < n; i++) begin
         wbyte(wbuf[i], a);
         if (i < 7) chk("R3 data ack", a, 1);
         else       chk("R5 extra data ack", a, 1);
         if (i < 6)       mdl[i] = wbuf[i];
         else if (i == 6) mdl[6] = (wbuf[6] & 8'h1F) | (mdl[6] & 8'hE0);
      end
      bus_stop();
      chk("R4 registers after stop", ctrl_regs, mdl_bus());
   endtask

   // Full read body after START: address, count, all registers.
   task automatic read_body(input string tag);
      logic a;
      logic [7:0] d;
      wbyte(8'hD5, a);  chk({tag, " read address ack"}, a, 1);
      rbyte(d, 1'b1);   chk({tag, " byte count"}, d, 8'h07);
      for (int i = 0; i < 7; i++) begin
         rbyte(d, i < 6);
         chk({tag, " read register"}, d, mdl[i]);
      end
      bus_stop();
      chk("R10 pair enables", pair_en, exp_pairs());
   endtask

   initial begin
      logic a, b;
      logic [7:0] d;
      int ones;
      void'($urandom(32'h5EED1234));
      for (int i = 0; i < 6; i++) mdl[i] = 8'hFF;
      mdl[6] = 8'h1F;
      rst_n = 1'b0;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      chk("R1 reset registers", ctrl_regs, 56'h1FFFFFFFFFFFFF);
      chk("R1 reset sda", sda_oe, 0);
      chk("R10 reset pair enables", pair_en, 10'h3FF);

      // R2: foreign address is ignored
      bus_start();
      wbyte(8'hA0, a);  chk("R2 foreign address no ack", a, 0);
      wbyte(8'h00, a);  chk("R2 no ack after foreign address", a, 0);
      bus_stop();
      chk("R2 registers unchanged", ctrl_regs, mdl_bus());

      // R3/R6: full write, locked bits in register 6
      wbuf[0] = 8'h00; wbuf[1] = 8'h5A; wbuf[2] = 8'hA5; wbuf[3] = 8'h3C;
      wbuf[4] = 8'hC3; wbuf[5] = 8'h81; wbuf[6] = 8'hE0;
      do_write(7);
      chk("R6 locked bits stay zero", ctrl_regs[55:48], 8'h00);
      bus_start(); read_body("R7");

      // R4: partial write
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      do_write(3);
      bus_start(); read_body("R4");

      // R5: nine data bytes
      for (int i = 0; i < 9; i++) wbuf[i] = 8'h40 + 8'(i);
      do_write(9);
      bus_start(); read_body("R5");

      // R9: START in the middle of a data byte
      bus_start();
      wbyte(8'hD4, a); wbyte(8'h00, a); wbyte(8'h00, a);
      wbyte(8'h77, a); chk("R9 first byte ack", a, 1);
      mdl[0] = 8'h77;
      wbit(1'b0); wbit(1'b1); wbit(1'b0); wbit(1'b0);
      bus_start();
      read_body("R9");

      // R8: NACK ends a read, slave stays off the bus
      wbuf[0] = 8'h12; wbuf[1] = 8'h00;
      do_write(2);
      bus_start();
      wbyte(8'hD5, a);  chk("R8 address ack", a, 1);
      rbyte(d, 1'b1);   chk("R8 byte count", d, 8'h07);
      rbyte(d, 1'b0);   chk("R8 register 0 before nack", d, 8'h12);
      ones = 0;
      for (int i = 0; i < 9; i++) begin
         rbit(b);
         if (b) ones++;
      end
      chk("R8 bus released after nack", ones, 9);
      bus_start();
      read_body("R8 repeated start");

      // Random writes and reads
      for (int it = 0; it < 10; it++) begin
         int n;
         n = int'($urandom % 10);
         for (int i = 0; i < 10; i++) wbuf[i] = 8'($urandom);
         do_write(n);
         chk("R6 locked bits random", ctrl_regs[55:53], 3'b000);
         bus_start(); read_body("R7 random");
      end

      chk("R11 sda moves only with scl low", oe_viol, 0);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule